// File: doc/BRIEF.md
# Boundary-Pausing DMA Address Engine

This block produces the word addresses for a single-address DMA transfer inside a memory-card host controller. It also pauses that transfer at programmable alignment boundaries and holds the normal interrupt status. Software loads a start address and then a byte length through a small register port. From then on the engine offers one word address per cycle on a valid/ready request port. The address steps by four bytes for each accepted request. When the next address would fall on a multiple of the selected boundary size, the engine stops and flags a boundary event. The transfer stays stopped for as long as software leaves it alone. It restarts only when software writes the address register.

The request port follows the usual valid/ready rules. A request counts as transferred on a cycle where `mreq_valid` and `mreq_ready` are both high. While `mreq_ready` is low, a pending request holds its address unchanged and `mreq_valid` stays high. The engine never withdraws a request until it has been accepted. `mreq_ready` has no effect while `mreq_valid` is low.

The status register latches several events: command complete, transfer complete, boundary pause, write-buffer ready and read-buffer ready. An event is latched only if its status-enable bit is set. Software clears a status bit by writing 1 to it. The interrupt pin combines the latched bits with a separate signal-enable mask. Register reads are combinational on `reg_sel`. Register writes take effect at the clock edge where `reg_wr` is high.

Top module: `dbe_bnd_engine`

## Requirements
- R1: After reset, the registers read as follows: address 0, remaining length 0, boundary field 7, status 0, status-enable 0 and signal-enable 0. `mreq_valid` and `irq` are both low.
- R2: Writing a length to select 1 while the engine is idle starts a transfer, provided the length with its two low bits cleared is nonzero. `mreq_valid` rises in the next cycle, carrying the stored address. Each accepted request adds 4 to the address and subtracts 4 from the remaining count. A request that is not accepted keeps `mreq_valid` high and `mreq_addr` unchanged.
- R3: The boundary size is 4096 << field, where the field is bits [2:0] of select 2. A pause is raised when an accepted request leaves a nonzero remaining count and the next address is a multiple of the boundary size. On a pause, `mreq_valid` drops and status bit 3 is set if enabled. The pause lasts until the address register is written.
- R4: While paused, reading select 0 returns the address of the next word to transfer.
- R5: Writing select 0 loads the written value, with its two low bits cleared, as the current address. If the engine is paused, the same write resumes the transfer, and the next request carries the new address.
- R6: Writing select 0 while idle only stores the address (two low bits read as zero). No request is issued.
- R7: When the remaining count reaches zero, `mreq_valid` drops and status bit 1 is set if enabled. No pause and no bit 3 occur, even if the address after the last word is a boundary multiple.
- R8: Writing select 1 while a transfer is in progress, paused or not, is ignored. The remaining count reads back unchanged.
- R9: Writing select 3 clears every status bit written as 1 and leaves bits written as 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: An event whose bit in the status-enable register (select 4, bits [15:0]) is 0 never sets its status bit. A boundary pause still happens in that case.
- R11: `irq` is high exactly when some status bit is set whose bit in the signal-enable register (select 5, bits [15:0]) is also set.
- R12: The event inputs latch as follows when enabled: `ev_cmd_done` sets bit 0, `ev_wbuf_ready` sets bit 4 and `ev_rbuf_ready` sets bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 address, 1 length, 2 boundary field, 3 status, 4 status-enable, 5 signal-enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| ev_cmd_done | input | 1 | Command-complete event pulse |
| ev_wbuf_ready | input | 1 | Write-buffer-ready event pulse |
| ev_rbuf_ready | input | 1 | Read-buffer-ready event pulse |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_addr | output | 32 | Word address of the current request |
| irq | output | 1 | Interrupt output |

## Verification
A wrong address or remaining count shows up on `mreq_addr` in the first cycle the request is offered. A wrong count also shows up as a transfer that ends one word early or late. A stuck or missing pause flag shows up on `mreq_valid` in the cycle after the boundary handshake. Either an extra request is issued, or the engine stalls where it should keep going. Status and enable faults reach `irq` and the status read one cycle after the event. The bench compares request validity, address and interrupt against a behavioural model on every clock. This catches each of these faults within a cycle of its cause.

// File: rtl/dbe_pkg.sv
`timescale 1ns/1ps
package dbe_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_LEN  = 3'd1,
    SEL_CFG  = 3'd2,
    SEL_STAT = 3'd3,
    SEL_STEN = 3'd4,
    SEL_SGEN = 3'd5
  } reg_sel_e;

  // status bit positions; software decodes these
  localparam int ST_CMD  = 0;
  localparam int ST_XFER = 1;
  localparam int ST_BND  = 3;
  localparam int ST_WRDY = 4;
  localparam int ST_RRDY = 5;
endpackage

// File: rtl/dbe_addr_gen.sv
`timescale 1ns/1ps
module dbe_addr_gen #(
  parameter int AW         = 32,
  parameter int FW         = 3,
  parameter int BASE_SHIFT = 12,
  parameter int WORD_BYTES = 4,
  parameter int FIELD_RST  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic          len_wr,
  input  logic          cfg_wr,
  input  logic [AW-1:0] wdata,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] remaining,
  output logic [FW-1:0] field,
  output logic          busy,
  output logic          paused,
  output logic          done_pulse,
  output logic          bnd_pulse
);
  localparam int ALIGN = $clog2(WORD_BYTES);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] wdata_al;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] rem_next;
  logic [AW-1:0] bnd_mask;
  logic          hs;
  logic          last_word;
  logic          at_bnd;
  logic          start;

  assign wdata_al  = {wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
  assign hs        = busy & ~paused & req_ready;
  assign next_addr = cur_addr + STEP;
  assign rem_next  = remaining - STEP;
  assign bnd_mask  = (ONE << (BASE_SHIFT + int'(field))) - ONE;
  assign last_word = (rem_next == '0);
  assign at_bnd    = ((next_addr & bnd_mask) == '0);
  assign start     = len_wr & ~busy & (wdata_al != '0);

  assign done_pulse = hs & last_word;
  assign bnd_pulse  = hs & ~last_word & at_bnd;
  assign req_valid  = busy & ~paused;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (addr_wr) begin
      cur_addr <= wdata_al;
    end else if (hs) begin
      cur_addr <= next_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (len_wr && !busy) begin
      remaining <= wdata_al;
    end else if (hs) begin
      remaining <= rem_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
    end else if (done_pulse) begin
      busy <= 1'b0;
    end
  end

  // an address write cancels any pause, including one raised in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      paused <= 1'b0;
    end else if (addr_wr) begin
      paused <= 1'b0;
    end else if (bnd_pulse) begin
      paused <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field <= FW'(FIELD_RST);
    end else if (cfg_wr) begin
      field <= wdata[FW-1:0];
    end
  end
endmodule

// File: rtl/dbe_irq_status.sv
`timescale 1ns/1ps
module dbe_irq_status #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] ev_raw,
  input  logic          clr_wr,
  input  logic          sten_wr,
  input  logic          sgen_wr,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] status,
  output logic [SW-1:0] sten,
  output logic [SW-1:0] sgen,
  output logic          irq
);
  for (genvar i = 0; i < SW; i++) begin : g_bit
    logic set_i;
    logic clr_i;
    assign set_i = ev_raw[i] & sten[i];
    assign clr_i = clr_wr & wdata[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status[i] <= 1'b0;
      end else if (set_i) begin
        status[i] <= 1'b1;
      end else if (clr_i) begin
        status[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sten <= '0;
      sgen <= '0;
    end else begin
      if (sten_wr) sten <= wdata;
      if (sgen_wr) sgen <= wdata;
    end
  end

  assign irq = |(status & sgen);
endmodule

// File: rtl/dbe_bnd_engine.sv
`timescale 1ns/1ps
module dbe_bnd_engine #(
  parameter int DW         = 32,
  parameter int SW         = 16,
  parameter int FW         = 3,
  parameter int BASE_SHIFT = 12,
  parameter int WORD_BYTES = 4,
  parameter int FIELD_RST  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_cmd_done,
  input  logic          ev_wbuf_ready,
  input  logic          ev_rbuf_ready,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic [DW-1:0] mreq_addr,
  output logic          irq
);
  import dbe_pkg::*;

  logic          wr_addr, wr_len, wr_cfg, wr_stat, wr_sten, wr_sgen;
  logic [DW-1:0] st_addr;
  logic [DW-1:0] st_remaining;
  logic [FW-1:0] st_field;
  logic          st_busy;
  logic          st_paused;
  logic          done_pulse;
  logic          bnd_pulse;
  logic [SW-1:0] ev_raw;
  logic [SW-1:0] st_status;
  logic [SW-1:0] st_sten;
  logic [SW-1:0] st_sgen;

  assign wr_addr = reg_wr & (reg_sel == SEL_ADDR);
  assign wr_len  = reg_wr & (reg_sel == SEL_LEN);
  assign wr_cfg  = reg_wr & (reg_sel == SEL_CFG);
  assign wr_stat = reg_wr & (reg_sel == SEL_STAT);
  assign wr_sten = reg_wr & (reg_sel == SEL_STEN);
  assign wr_sgen = reg_wr & (reg_sel == SEL_SGEN);

  dbe_addr_gen #(
    .AW(DW), .FW(FW), .BASE_SHIFT(BASE_SHIFT),
    .WORD_BYTES(WORD_BYTES), .FIELD_RST(FIELD_RST)
  ) u_agen (
    .clk(clk), .rst_n(rst_n),
    .addr_wr(wr_addr), .len_wr(wr_len), .cfg_wr(wr_cfg),
    .wdata(reg_wdata), .req_ready(mreq_ready), .req_valid(mreq_valid),
    .cur_addr(st_addr), .remaining(st_remaining), .field(st_field),
    .busy(st_busy), .paused(st_paused),
    .done_pulse(done_pulse), .bnd_pulse(bnd_pulse)
  );

  assign mreq_addr = st_addr;

  always_comb begin
    ev_raw          = '0;
    ev_raw[ST_CMD]  = ev_cmd_done;
    ev_raw[ST_XFER] = done_pulse;
    ev_raw[ST_BND]  = bnd_pulse;
    ev_raw[ST_WRDY] = ev_wbuf_ready;
    ev_raw[ST_RRDY] = ev_rbuf_ready;
  end

  dbe_irq_status #(.SW(SW)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev_raw(ev_raw),
    .clr_wr(wr_stat), .sten_wr(wr_sten), .sgen_wr(wr_sgen),
    .wdata(reg_wdata[SW-1:0]),
    .status(st_status), .sten(st_sten), .sgen(st_sgen), .irq(irq)
  );

  always_comb begin
    case (reg_sel)
      SEL_ADDR: reg_rdata = st_addr;
      SEL_LEN:  reg_rdata = st_remaining;
      SEL_CFG:  reg_rdata = {{(DW-FW){1'b0}}, st_field};
      SEL_STAT: reg_rdata = {{(DW-SW){1'b0}}, st_status};
      SEL_STEN: reg_rdata = {{(DW-SW){1'b0}}, st_sten};
      SEL_SGEN: reg_rdata = {{(DW-SW){1'b0}}, st_sgen};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbe_chk.sv
`timescale 1ns/1ps
module dbe_chk #(
  parameter int DW         = 32,
  parameter int SW         = 16,
  parameter int FW         = 3,
  parameter int BASE_SHIFT = 12,
  parameter int WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_sel,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic [DW-1:0] mreq_addr,
  input logic          irq,
  input logic          st_busy,
  input logic          st_paused,
  input logic [DW-1:0] st_remaining,
  input logic [FW-1:0] st_field,
  input logic [SW-1:0] st_status,
  input logic [SW-1:0] st_sten
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] STEP = DW'(WORD_BYTES);

  logic          addr_w;
  logic [DW-1:0] mask;
  assign addr_w = reg_wr && (reg_sel == 3'd0);
  assign mask   = (ONE << (BASE_SHIFT + int'(st_field))) - ONE;

  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready && !addr_w) |=> (mreq_valid && $stable(mreq_addr)));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready && !addr_w) |=> (mreq_addr == $past(mreq_addr) + STEP));

  assert_pause_at_bnd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready && !addr_w && st_remaining != STEP &&
     ((mreq_addr + STEP) & mask) == '0) |=> !mreq_valid);

  assert_pause_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_paused && !addr_w) |=> (st_paused && !mreq_valid));

  assert_len_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && reg_wr && reg_sel == 3'd1 && !(mreq_valid && mreq_ready))
      |=> (st_remaining == $past(st_remaining)));

  assert_masked_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_status & ~$past(st_status) & ~$past(st_sten)) == '0));

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_status != '0));
endmodule

bind dbe_bnd_engine dbe_chk #(
  .DW(DW), .SW(SW), .FW(FW), .BASE_SHIFT(BASE_SHIFT), .WORD_BYTES(WORD_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
  .irq(irq), .st_busy(st_busy), .st_paused(st_paused),
  .st_remaining(st_remaining), .st_field(st_field),
  .st_status(st_status), .st_sten(st_sten)
);

// File: tb/dbe_bnd_engine_tb_top.sv
`timescale 1ns/1ps
module dbe_bnd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        ev_cmd_done = 1'b0;
  logic        ev_wbuf_ready = 1'b0;
  logic        ev_rbuf_ready = 1'b0;
  logic        mreq_valid;
  logic        mreq_ready = 1'b1;
  logic [31:0] mreq_addr;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  logic [31:0] m_addr, m_rem;
  logic [2:0]  m_field;
  bit          m_busy, m_paused;
  logic [15:0] m_stat, m_sten, m_sgen;

  always #2.5 clk = ~clk;

  dbe_bnd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_cmd_done(ev_cmd_done), .ev_wbuf_ready(ev_wbuf_ready),
    .ev_rbuf_ready(ev_rbuf_ready), .mreq_valid(mreq_valid),
    .mreq_ready(mreq_ready), .mreq_addr(mreq_addr), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    logic [31:0] na, nr, bsz;
    logic [15:0] evs, clr;
    bit nb, np, hs;
    if (!rst_n) begin
      m_addr = 0; m_rem = 0; m_field = 3'd7; m_busy = 0; m_paused = 0;
      m_stat = 0; m_sten = 0; m_sgen = 0;
    end else begin
      hs = m_busy && !m_paused && mreq_ready;
      na = m_addr; nr = m_rem; nb = m_busy; np = m_paused;
      evs = 16'h0; clr = 16'h0;
      evs[0] = ev_cmd_done; evs[4] = ev_wbuf_ready; evs[5] = ev_rbuf_ready;
      bsz = 32'h1000 << m_field;
      if (hs) begin
        na = m_addr + 4;
        nr = m_rem - 4;
        if (nr == 0) begin
          nb = 0; evs[1] = 1'b1;
        end else if ((na % bsz) == 0) begin
          np = 1; evs[3] = 1'b1;
        end
      end
      if (reg_wr) begin
        case (reg_sel)
          3'd0: begin na = reg_wdata & ~32'h3; np = 0; end
          3'd1: if (!m_busy) begin
                  nr = reg_wdata & ~32'h3;
                  if (nr != 0) nb = 1;
                end
          3'd2: m_field = reg_wdata[2:0];
          3'd3: clr = reg_wdata[15:0];
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | (evs & m_sten);
      if (reg_wr && reg_sel == 3'd4) m_sten = reg_wdata[15:0];
      if (reg_wr && reg_sel == 3'd5) m_sgen = reg_wdata[15:0];
      m_addr = na; m_rem = nr; m_busy = nb; m_paused = np;
    end
  end

  // ready pattern and every-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk("R2", "mreq_valid", {31'd0, mreq_valid}, {31'd0, m_busy && !m_paused});
      if (mreq_valid) chk("R2", "mreq_addr", mreq_addr, m_addr);
      chk("R11", "irq", {31'd0, irq}, {31'd0, |(m_stat & m_sgen)});
    end
    mreq_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic reg_write(logic [2:0] sel, logic [31:0] data, logic [2:0] ev = 3'b000);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    {ev_rbuf_ready, ev_wbuf_ready, ev_cmd_done} = ev;
    @(negedge clk);
    reg_wr = 1'b0;
    {ev_rbuf_ready, ev_wbuf_ready, ev_cmd_done} = 3'b000;
  endtask

  task automatic reg_read(logic [2:0] sel, output logic [31:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic chk_reg(string req, logic [2:0] sel, logic [31:0] exp);
    logic [31:0] v;
    reg_read(sel, v);
    chk(req, $sformatf("reg%0d", sel), v, exp);
  endtask

  task automatic wait_stop();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!m_busy || m_paused) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1 reset values
    chk_reg("R1", 3'd0, 32'h0);
    chk_reg("R1", 3'd1, 32'h0);
    chk_reg("R1", 3'd2, 32'h7);
    chk_reg("R1", 3'd3, 32'h0);
    chk_reg("R1", 3'd4, 32'h0);
    chk_reg("R1", 3'd5, 32'h0);
    chk("R1", "valid", {31'd0, mreq_valid}, 32'd0);
    chk("R1", "irq", {31'd0, irq}, 32'd0);

    reg_write(3'd4, 32'h003B);
    reg_write(3'd5, 32'h000A);
    reg_write(3'd2, 32'h0);
    // R6 idle address write only stores
    reg_write(3'd0, 32'h0000_0FF2);
    repeat (4) @(negedge clk);
    chk("R6", "valid idle", {31'd0, mreq_valid}, 32'd0);
    chk_reg("R6", 3'd0, 32'h0FF0);

    // R2 start, with back-pressure
    stall_en = 1'b1;
    reg_write(3'd1, 32'h20);
    chk("R2", "valid after start", {31'd0, mreq_valid}, 32'd1);
    chk("R2", "first addr", mreq_addr, 32'h0FF0);
    wait_stop();
    // R3/R4 pause at 4 KiB boundary
    chk("R3", "valid paused", {31'd0, mreq_valid}, 32'd0);
    chk_reg("R4", 3'd0, 32'h1000);
    chk_reg("R3", 3'd1, 32'h10);
    chk_reg("R3", 3'd3, 32'h08);
    chk("R11", "irq bnd", {31'd0, irq}, 32'd1);
    repeat (10) @(negedge clk);
    chk("R3", "still paused", {31'd0, mreq_valid}, 32'd0);
    // R8 length ignored while busy
    reg_write(3'd1, 32'h100);
    chk_reg("R8", 3'd1, 32'h10);
    // R9 write-one-to-clear
    reg_write(3'd3, 32'h0);
    chk_reg("R9", 3'd3, 32'h08);
    reg_write(3'd3, 32'h08);
    chk_reg("R9", 3'd3, 32'h00);
    chk("R11", "irq cleared", {31'd0, irq}, 32'd0);
    // R5 resume by address write back
    reg_write(3'd0, 32'h1000);
    chk("R5", "resume valid", {31'd0, mreq_valid}, 32'd1);
    chk("R5", "resume addr", mreq_addr, 32'h1000);
    wait_stop();
    chk_reg("R7", 3'd3, 32'h02);
    chk_reg("R7", 3'd1, 32'h0);
    chk_reg("R7", 3'd0, 32'h1010);
    reg_write(3'd3, 32'h02);

    // R7 last word ending on a boundary: no pause
    stall_en = 1'b0;
    reg_write(3'd0, 32'h1FF0);
    reg_write(3'd1, 32'h10);
    wait_stop();
    chk_reg("R7", 3'd3, 32'h02);
    chk_reg("R7", 3'd0, 32'h2000);
    chk("R7", "idle valid", {31'd0, mreq_valid}, 32'd0);
    reg_write(3'd3, 32'h02);

    // R10 boundary bit disabled, 8 KiB boundary, pause still happens
    reg_write(3'd4, 32'h0033);
    reg_write(3'd2, 32'h1);
    reg_write(3'd0, 32'h1FF8);
    reg_write(3'd1, 32'h10);
    wait_stop();
    chk_reg("R10", 3'd3, 32'h0);
    chk_reg("R3", 3'd0, 32'h2000);
    chk("R10", "paused valid", {31'd0, mreq_valid}, 32'd0);
    reg_write(3'd0, 32'h8000);
    chk("R5", "relocated addr", mreq_addr, 32'h8000);
    wait_stop();
    chk_reg("R5", 3'd0, 32'h8008);
    chk_reg("R7", 3'd3, 32'h02);

    // R12 event sources
    reg_write(3'd3, 32'hFFFF);
    reg_write(3'd3, 32'h0, 3'b001);
    chk_reg("R12", 3'd3, 32'h01);
    reg_write(3'd3, 32'h0, 3'b110);
    chk_reg("R12", 3'd3, 32'h31);
    chk("R11", "irq no enabled bit", {31'd0, irq}, 32'd0);
    reg_write(3'd5, 32'h0010);
    chk("R11", "irq bit4", {31'd0, irq}, 32'd1);
    reg_write(3'd3, 32'h31);
    chk_reg("R9", 3'd3, 32'h0);
    // R10 events masked
    reg_write(3'd4, 32'h0);
    reg_write(3'd3, 32'h0, 3'b111);
    chk_reg("R10", 3'd3, 32'h0);
    // R9 set beats clear
    reg_write(3'd4, 32'h0001);
    reg_write(3'd3, 32'h01, 3'b001);
    chk_reg("R9", 3'd3, 32'h01);
    reg_write(3'd5, 32'h0001);
    chk("R11", "irq bit0", {31'd0, irq}, 32'd1);
    reg_write(3'd5, 32'h0);
    chk("R11", "irq masked", {31'd0, irq}, 32'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule